// File: doc/BRIEF.md
# Relocatable Memory-Map Address Decoder

This block sits between the CPU bus of a small 8-bit controller and its memories. Each bus cycle it picks one target for the address: the 64-byte control/status register block, the 192-byte on-chip static RAM, the on-chip program ROM or the external bus. It also gives the offset of the address inside the chosen region. An 8-bit mapping register places the RAM and the register block, each on any 4 KB page. When regions overlap, a fixed priority decides which one wins. The decode is combinational, so the selects follow the address in the same cycle.

The mapping register lives inside the register block at offset 0x3D. In normal operating modes, software may write it once, and only within a fixed number of E-cycle strobes after reset. After that it can only be read. In special modes it can be written at any time and any number of times.

The mode inputs and the E-cycle strobe come from logic outside this block and enter as plain inputs.

Top module: `addr_map_decoder`

## Requirements
- R1: After reset the mapping register is 0x00. The register block then decodes at 0x0000–0x003F and the RAM is visible from 0x0040 to 0x00BF.
- R2: The mapping register is at register-block offset 0x3D. Bits 7:4 give the upper four address bits of the RAM base and bits 3:0 give those of the register-block base. An accepted write changes the decode from the next clock cycle on.
- R3: The RAM spans base to base+191. Address base+192 and higher on the same page do not select the RAM.
- R4: Overlaps resolve in the order register block, RAM, ROM, external bus. When busValid is 1, exactly one of selReg, selRam, selRom and selExt is 1. When busValid is 0, none of them is 1.
- R5: The ROM decodes at 0xF000–0xFFFF except when modeNormal=1 and modeExpanded=1. In that mode those addresses go to the external bus.
- R6: With modeNormal=1, only the first accepted write changes the mapping register. Later writes leave it unchanged.
- R7: With modeNormal=1, a write is accepted while fewer than 64 E-cycle strobes have been seen since reset. From the 64th strobe on, writes are ignored and mapWindowOpen is 0. The strobe counter saturates and never reopens the window.
- R8: With modeNormal=0, every write to the mapping register is accepted, whatever the strobe count and the number of earlier writes.
- R9: A read of an unused register-block offset (0x10–0x1F, 0x38–0x3B) selects only the register block and keeps rdDataValid at 0. extDataEn is 1 only for a read that selects the external bus.
- R10: regOffset is address bits 5:0, ramOffset is address bits 7:0 and romOffset is address bits 11:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeNormal | input | 1 | 1 = normal mode (write-once applies) |
| modeExpanded | input | 1 | 1 = expanded mode (external bus in use) |
| eTick | input | 1 | One-cycle strobe per E-cycle |
| busValid | input | 1 | Bus cycle present |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 16 | Bus address |
| busWdata | input | 8 | Write data |
| selReg | output | 1 | Register block selected |
| selRam | output | 1 | RAM selected |
| selRom | output | 1 | Program ROM selected |
| selExt | output | 1 | External bus selected |
| regOffset | output | 6 | Offset within the register block |
| ramOffset | output | 8 | Offset within the RAM |
| romOffset | output | 12 | Offset within the ROM |
| rdDataValid | output | 1 | A read drives the internal data bus |
| extDataEn | output | 1 | External read data may enter the internal bus |
| mapRegOut | output | 8 | Current mapping register value |
| mapWindowOpen | output | 1 | A mapping write would be accepted now |

## Verification
The bench builds the block with its default parameters: a 64-strobe window, 192 bytes of RAM, a 64-byte register block and the ROM on page 0xF. With these values, the window edge at strobes 63 and 64 can be reached directly. So can the counter's 7-bit wrap point at 128 strobes, which tests that the counter saturates. Placing both regions on page 0xF builds the three-way overlap of register block, RAM and ROM, so each step of the priority order shows at the ports.

// File: rtl/amd_pkg.sv
package amd_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic mapLoad;     // capture write data into the mapping register
    logic windowOpen;  // a mapping write would be accepted now
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    KIND_REG = 2'd0,
    KIND_RAM = 2'd1,
    KIND_ROM = 2'd2,
    KIND_EXT = 2'd3
  } selKind_t;

endpackage

// File: rtl/amd_ctrl.sv
module amd_ctrl
  import amd_pkg::*;
#(
  parameter int WIN_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeNormal,
  input  logic       eTick,
  input  logic       mapWrHit,
  output ctlStrobe_t strobe
);

  localparam int CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIN_CYCLES);

  logic [CNT_W-1:0] tickCnt;
  logic             wasWritten;
  logic             openNow;

  always_comb begin
    openNow         = !modeNormal || ((tickCnt < CNT_MAX) && !wasWritten);
    strobe.windowOpen = openNow;
    strobe.mapLoad    = mapWrHit && openNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt    <= '0;
      wasWritten <= 1'b0;
    end else begin
      if (eTick && (tickCnt < CNT_MAX))
        tickCnt <= tickCnt + 1'b1;
      if (strobe.mapLoad && modeNormal)
        wasWritten <= 1'b1;
    end
  end

  // R7: the counter never passes its limit
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= CNT_MAX);

  // R7: once the counter reaches its limit, it stays there
  p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tickCnt == CNT_MAX) |=> (tickCnt == CNT_MAX));

  // R6: in normal mode, a load is never followed by a second load
  p_once_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mapLoad && modeNormal) |=> (!modeNormal || !strobe.mapLoad));

  // R7: in normal mode, no load once the window has closed
  p_late_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeNormal && (tickCnt == CNT_MAX)) |-> !strobe.mapLoad);

endmodule

// File: rtl/amd_datapath.sv
module amd_datapath
  import amd_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          PAGE_W     = 4,
  parameter int          RAM_BYTES  = 192,
  parameter int          REG_BYTES  = 64,
  parameter int          ROM_PAGE   = 15,
  parameter int          MAP_OFFSET = 61,
  parameter logic [63:0] USED_MASK  = 64'hF0FF_FFFF_0000_FFFF,
  localparam int OFF_W     = ADDR_W - PAGE_W,
  localparam int REG_OFF_W = $clog2(REG_BYTES),
  localparam int RAM_OFF_W = $clog2(RAM_BYTES),
  localparam int MAP_W     = 2 * PAGE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 modeNormal,
  input  logic                 modeExpanded,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [MAP_W-1:0]     busWdata,
  input  ctlStrobe_t           strobe,
  output logic                 mapWrHit,
  output logic                 selReg,
  output logic                 selRam,
  output logic                 selRom,
  output logic                 selExt,
  output logic [REG_OFF_W-1:0] regOffset,
  output logic [RAM_OFF_W-1:0] ramOffset,
  output logic [OFF_W-1:0]     romOffset,
  output logic                 rdDataValid,
  output logic                 extDataEn,
  output logic [MAP_W-1:0]     mapRegOut
);

  localparam logic [OFF_W-1:0]     REG_LIM  = OFF_W'(REG_BYTES);
  localparam logic [OFF_W-1:0]     RAM_LIM  = OFF_W'(RAM_BYTES);
  localparam logic [PAGE_W-1:0]    ROM_PG   = PAGE_W'(ROM_PAGE);
  localparam logic [REG_OFF_W-1:0] MAP_OFF  = REG_OFF_W'(MAP_OFFSET);

  logic [MAP_W-1:0]  mapQ;
  logic [PAGE_W-1:0] regPage, ramPage, addrPage;
  logic [OFF_W-1:0]  inPage;
  logic              regHit, ramHit, romHit, romEn;
  logic              isRead, slotUsed;
  selKind_t          kind;

  assign regPage  = mapQ[PAGE_W-1:0];
  assign ramPage  = mapQ[MAP_W-1:PAGE_W];
  assign addrPage = busAddr[ADDR_W-1 -: PAGE_W];
  assign inPage   = busAddr[OFF_W-1:0];

  assign romEn  = !(modeNormal && modeExpanded);
  assign regHit = (addrPage == regPage) && (inPage < REG_LIM);
  assign ramHit = (addrPage == ramPage) && (inPage < RAM_LIM);
  assign romHit = romEn && (addrPage == ROM_PG);

  // fixed priority: register block, RAM, ROM, external
  always_comb begin
    if (regHit)      kind = KIND_REG;
    else if (ramHit) kind = KIND_RAM;
    else if (romHit) kind = KIND_ROM;
    else             kind = KIND_EXT;
  end

  assign selReg = busValid && (kind == KIND_REG);
  assign selRam = busValid && (kind == KIND_RAM);
  assign selRom = busValid && (kind == KIND_ROM);
  assign selExt = busValid && (kind == KIND_EXT);

  assign regOffset = busAddr[REG_OFF_W-1:0];
  assign ramOffset = busAddr[RAM_OFF_W-1:0];
  assign romOffset = inPage;

  assign isRead      = busValid && !busWrite;
  assign slotUsed    = USED_MASK[regOffset];
  assign rdDataValid = isRead && (!selReg || slotUsed);
  assign extDataEn   = isRead && selExt;
  assign mapWrHit    = busValid && busWrite && selReg && (regOffset == MAP_OFF);
  assign mapRegOut   = mapQ;

  always_ff @(posedge clk) begin
    if (!rstN)               mapQ <= '0;
    else if (strobe.mapLoad) mapQ <= busWdata;
  end

  // R4: one select per valid cycle
  p_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> ($countones({selReg, selRam, selRom, selExt}) == 1));

  // R4: no select without a bus cycle
  p_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> ({selReg, selRam, selRom, selExt} == 4'b0000));

  // R9: external data never enters the internal bus for an internal target
  p_ext_guard_r9: assert property (@(posedge clk) disable iff (!rstN)
    extDataEn |-> !(selReg || selRam || selRom));

  // R2: an accepted write shows in the register on the next cycle
  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mapLoad |=> (mapQ == $past(busWdata)));

  // R5: ROM is never selected in normal expanded mode
  p_rom_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeNormal && modeExpanded) |-> !selRom);

  // R2: without a load the register holds its value
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.mapLoad |=> $stable(mapQ));

endmodule

// File: rtl/addr_map_decoder.sv
module addr_map_decoder
  import amd_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          PAGE_W     = 4,
  parameter int          RAM_BYTES  = 192,
  parameter int          REG_BYTES  = 64,
  parameter int          ROM_PAGE   = 15,
  parameter int          MAP_OFFSET = 61,
  parameter int          WIN_CYCLES = 64,
  parameter logic [63:0] USED_MASK  = 64'hF0FF_FFFF_0000_FFFF
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          modeNormal,
  input  logic                          modeExpanded,
  input  logic                          eTick,
  input  logic                          busValid,
  input  logic                          busWrite,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [2*PAGE_W-1:0]           busWdata,
  output logic                          selReg,
  output logic                          selRam,
  output logic                          selRom,
  output logic                          selExt,
  output logic [$clog2(REG_BYTES)-1:0]  regOffset,
  output logic [$clog2(RAM_BYTES)-1:0]  ramOffset,
  output logic [ADDR_W-PAGE_W-1:0]      romOffset,
  output logic                          rdDataValid,
  output logic                          extDataEn,
  output logic [2*PAGE_W-1:0]           mapRegOut,
  output logic                          mapWindowOpen
);

  ctlStrobe_t strobe;
  logic       mapWrHit;

  amd_ctrl #(.WIN_CYCLES(WIN_CYCLES)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .modeNormal (modeNormal),
    .eTick      (eTick),
    .mapWrHit   (mapWrHit),
    .strobe     (strobe)
  );

  amd_datapath #(
    .ADDR_W     (ADDR_W),
    .PAGE_W     (PAGE_W),
    .RAM_BYTES  (RAM_BYTES),
    .REG_BYTES  (REG_BYTES),
    .ROM_PAGE   (ROM_PAGE),
    .MAP_OFFSET (MAP_OFFSET),
    .USED_MASK  (USED_MASK)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .modeNormal   (modeNormal),
    .modeExpanded (modeExpanded),
    .busValid     (busValid),
    .busWrite     (busWrite),
    .busAddr      (busAddr),
    .busWdata     (busWdata),
    .strobe       (strobe),
    .mapWrHit     (mapWrHit),
    .selReg       (selReg),
    .selRam       (selRam),
    .selRom       (selRom),
    .selExt       (selExt),
    .regOffset    (regOffset),
    .ramOffset    (ramOffset),
    .romOffset    (romOffset),
    .rdDataValid  (rdDataValid),
    .extDataEn    (extDataEn),
    .mapRegOut    (mapRegOut)
  );

  assign mapWindowOpen = strobe.windowOpen;

endmodule

// File: tb/addr_map_decoder_tb_top.sv
module addr_map_decoder_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [3:0] S_REG = 4'b0001;
  localparam logic [3:0] S_RAM = 4'b0010;
  localparam logic [3:0] S_ROM = 4'b0100;
  localparam logic [3:0] S_EXT = 4'b1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeNormal = 1'b1;
  logic        modeExpanded = 1'b0;
  logic        eTick = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic        selReg, selRam, selRom, selExt;
  logic [5:0]  regOffset;
  logic [7:0]  ramOffset;
  logic [11:0] romOffset;
  logic        rdDataValid, extDataEn;
  logic [7:0]  mapRegOut;
  logic        mapWindowOpen;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  addr_map_decoder dut_i (
    .clk(clk), .rstN(rstN), .modeNormal(modeNormal), .modeExpanded(modeExpanded),
    .eTick(eTick), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .selReg(selReg), .selRam(selRam), .selRom(selRom),
    .selExt(selExt), .regOffset(regOffset), .ramOffset(ramOffset),
    .romOffset(romOffset), .rdDataValid(rdDataValid), .extDataEn(extDataEn),
    .mapRegOut(mapRegOut), .mapWindowOpen(mapWindowOpen)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit slotUnused(logic [5:0] off);
    return ((off >= 6'h10) && (off <= 6'h1F)) || ((off >= 6'h38) && (off <= 6'h3B));
  endfunction

  task automatic doReset(bit normal, bit expanded);
    @(negedge clk);
    rstN = 1'b0; modeNormal = normal; modeExpanded = expanded;
    busValid = 1'b0; busWrite = 1'b0; eTick = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tickN(int n);
    @(negedge clk);
    eTick = 1'b1;
    repeat (n) @(negedge clk);
    eTick = 1'b0;
  endtask

  task automatic busWr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  // read probe: checks select, read-valid and external enable
  task automatic probe(string tag, logic [15:0] a, logic [3:0] expSel);
    bit expRd;
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1;
    expRd = !((expSel == S_REG) && slotUnused(a[5:0]));
    chk(tag, {selExt, selRom, selRam, selReg}, expSel);
    chk({tag, " rdDataValid"}, rdDataValid, expRd);
    chk({tag, " extDataEn"}, extDataEn, expSel == S_EXT);
    busValid = 1'b0;
  endtask

  task automatic testReset();
    doReset(1, 0);
    #1;
    chk("R1 map reset", mapRegOut, 8'h00);
    chk("R7 window open at reset", mapWindowOpen, 1);
    @(negedge clk); #1;
    chk("R4 idle no select", {selExt, selRom, selRam, selReg}, 4'b0000);
    probe("R1 reg low", 16'h0000, S_REG);
    probe("R1 reg high", 16'h003F, S_REG);
    probe("R1 ram low", 16'h0040, S_RAM);
    probe("R3 ram high", 16'h00BF, S_RAM);
    probe("R3 past ram", 16'h00C0, S_EXT);
    probe("R5 rom low", 16'hF000, S_ROM);
    probe("R5 rom high", 16'hFFFF, S_ROM);
  endtask

  task automatic testRelocate();
    doReset(1, 0);
    busWr(16'h003D, 8'h21);
    #1;
    chk("R2 map value", mapRegOut, 8'h21);
    probe("R2 reg moved", 16'h1000, S_REG);
    probe("R2 map slot moved", 16'h103D, S_REG);
    probe("R2 ram moved", 16'h2000, S_RAM);
    probe("R3 ram top moved", 16'h20BF, S_RAM);
    probe("R3 ram past moved", 16'h20C0, S_EXT);
    probe("R2 old reg freed", 16'h0000, S_EXT);
    probe("R2 old ram freed", 16'h0040, S_EXT);
    // R6: second write ignored
    busWr(16'h103D, 8'h55);
    #1;
    chk("R6 second write ignored", mapRegOut, 8'h21);
    probe("R6 decode unchanged", 16'h1000, S_REG);
    chk("R6 window closed", mapWindowOpen, 0);
  endtask

  task automatic testWindow();
    doReset(1, 0);
    tickN(63);
    #1;
    chk("R7 open after 63", mapWindowOpen, 1);
    busWr(16'h003D, 8'h34);
    #1;
    chk("R7 write at 63 accepted", mapRegOut, 8'h34);
    doReset(1, 0);
    tickN(64);
    #1;
    chk("R7 closed after 64", mapWindowOpen, 0);
    busWr(16'h003D, 8'h34);
    #1;
    chk("R7 late write ignored", mapRegOut, 8'h00);
    tickN(200);
    #1;
    chk("R7 saturated closed", mapWindowOpen, 0);
    busWr(16'h003D, 8'h77);
    #1;
    chk("R7 write after wrap point ignored", mapRegOut, 8'h00);
    probe("R7 decode still default", 16'h0000, S_REG);
  endtask

  task automatic testSpecial();
    doReset(0, 0);
    tickN(100);
    busWr(16'h003D, 8'h30);
    #1;
    chk("R8 late write accepted", mapRegOut, 8'h30);
    busWr(16'h003D, 8'h5A);
    #1;
    chk("R8 second write accepted", mapRegOut, 8'h5A);
    chk("R8 window open", mapWindowOpen, 1);
    // priority overlap: reg, RAM and ROM all on page F
    busWr(16'hA03D, 8'hFF);
    #1;
    chk("R4 map all page F", mapRegOut, 8'hFF);
    probe("R4 reg over ram and rom", 16'hF000, S_REG);
    probe("R4 ram over rom", 16'hF040, S_RAM);
    probe("R4 rom after ram", 16'hF0C0, S_ROM);
    probe("R4 ext elsewhere", 16'h0000, S_EXT);
  endtask

  task automatic testExpanded();
    doReset(1, 1);
    probe("R5 rom off in normal expanded", 16'hF000, S_EXT);
    probe("R5 rom off top", 16'hFFFF, S_EXT);
    probe("R1 reg still internal", 16'h0005, S_REG);
  endtask

  task automatic testUnused();
    doReset(1, 0);
    probe("R9 unused 0x10", 16'h0010, S_REG);
    probe("R9 unused 0x1F", 16'h001F, S_REG);
    probe("R9 unused 0x38", 16'h0038, S_REG);
    probe("R9 used 0x3D", 16'h003D, S_REG);
    probe("R9 used 0x0F", 16'h000F, S_REG);
  endtask

  task automatic testOffsets();
    doReset(0, 0);
    busWr(16'h003D, 8'h21);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = 16'h20A5; #1;
    chk("R10 ram offset", ramOffset, 8'hA5);
    @(negedge clk);
    busAddr = 16'h1007; #1;
    chk("R10 reg offset", regOffset, 6'h07);
    @(negedge clk);
    busAddr = 16'hF123; #1;
    chk("R10 rom offset", romOffset, 12'h123);
    chk("R10 rom selected", selRom, 1);
    busValid = 1'b0;
  endtask

  initial begin
    testReset();
    testRelocate();
    testWindow();
    testSpecial();
    testExpanded();
    testUnused();
    testOffsets();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule